// File: doc/BRIEF.md
# Zero-Overhead Repeat-Block Sequencer

This block works next to a simple program counter and executes a repeat-block instruction. A repeat issue names a body length in instructions and an iteration count. The block records where the body starts and ends. After the final body instruction retires, it steers the next PC back to the body start, and it keeps doing so until the iterations are used up. No branch instruction is spent on the loop. The loop state changes only on an instruction-retire strobe, so memory stalls of any length inside the body leave the count untouched.

Any taken branch ends the loop, as if the count had run out, and execution goes on at the branch target. A relative target is always formed from the address of the branch itself. When a branch is the final body instruction, it overrides the loop-back, so the PC changes exactly once. A repeat issued inside an active body replaces the running loop instead of nesting inside it. Interrupt requests are held off for as long as a loop is active. Each operand can come from an immediate field or from a register value.

Top module: `hwl_rep_seq`

## Requirements
- R1: After reset `loop_active` and `irq_hold` are 0. A retiring instruction that is not a branch, not a repeat issue and not the final body instruction of a loop that continues gives `pc_next = pc_cur + 1`, taken modulo 2^AW.
- R2: While `retire` is 0, `pc_next` equals `pc_cur` and no loop state changes. Stall cycles do not count as iterations.
- R3: A retiring instruction with `br_taken` = 1 wins over every other action. It clears the loop, so `loop_active` is 0 in the next cycle.
- R4: With `br_relative` = 1 the target is `pc_cur` plus `br_offset`, sign-extended from 9 bits (two's complement), modulo 2^AW. This holds even at the final body instruction, where the branch replaces the loop-back. With `br_relative` = 0 the target is `br_target`.
- R5: A repeat issue with length L > 0 at address A gives `pc_next = A+1`, sets `loop_active` in the next cycle, and marks the body as A+1 to A+L. With count N > 0 the body runs exactly N times, for L*N body retires in total. After the last one, `pc_next` = A+L+1 and `loop_active` drops.
- R6: A repeat issue with length 0 acts as a plain instruction (`pc_next = pc_cur + 1`) and leaves `loop_active` at 0. If a loop was active, that loop ends.
- R7: A repeat issue inside an active body discards the old loop. It starts a new one from its own address, length and count.
- R8: `rep_len_from_reg` = 1 selects `rep_len_reg` over `rep_len_imm`. `rep_cnt_from_reg` = 1 selects `rep_cnt_reg` over `rep_cnt_imm`.
- R9: `irq_hold` is 1 exactly when `irq_req` is 1 and `loop_active` is 1. It drops in the cycle after the loop ends.
- R10: A count of 0 repeats the body with no limit until a taken branch or a new repeat issue. A count of 1 runs the body once with no loop-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rep_issue | input | 1 | The retiring instruction is a repeat issue |
| rep_len_imm | input | LW | Body length, immediate form |
| rep_len_reg | input | LW | Body length, register form |
| rep_len_from_reg | input | 1 | Take the length from the register form |
| rep_cnt_imm | input | CW | Iteration count, immediate form (0 = unlimited) |
| rep_cnt_reg | input | CW | Iteration count, register form |
| rep_cnt_from_reg | input | 1 | Take the count from the register form |
| pc_cur | input | AW | Address of the current instruction |
| retire | input | 1 | The current instruction retires this cycle |
| br_taken | input | 1 | The retiring instruction is a taken branch |
| br_relative | input | 1 | The branch target is PC-relative |
| br_offset | input | BW | Signed relative offset |
| br_target | input | AW | Absolute branch target |
| irq_req | input | 1 | Interrupt request from the controller |
| pc_next | output | AW | Address of the next instruction |
| loop_active | output | 1 | A repeat block is running |
| irq_hold | output | 1 | Interrupt request is being held off |

## Verification
The bench drives plain sequential code, counted loops (count 1 and larger counts), unlimited loops and stalled loops. Counting body retires tells an off-by-one count, or a stall that is counted as an iteration, apart from a correct loop. Forward and backward relative branches are placed at the first, middle and final body positions. This separates a target formed from the branch address from one formed from an already rewound PC, and it shows whether the final-position branch wins over the loop-back. Nested repeat issues, zero-length issues, register-sourced operands and an interrupt raised mid-loop check the replacement, no-op, operand-select and hold behaviour. A behavioural PC model is compared with the outputs on every clock.

// File: rtl/hwl_pkg.sv
package hwl_pkg;

    // Action chosen for the current cycle by the PC steering logic
    typedef enum logic [2:0] {
        ACT_HOLD     = 3'd0,   // no retire: nothing moves
        ACT_SEQ      = 3'd1,   // fall through to pc + 1
        ACT_BRANCH   = 3'd2,   // taken branch, loop cancelled
        ACT_REP      = 3'd3,   // repeat issue with non-zero length
        ACT_REP_NULL = 3'd4,   // repeat issue with zero length
        ACT_LOOPBACK = 3'd5,   // final body instruction, go back to start
        ACT_EXIT     = 3'd6    // final body instruction, iterations done
    } hwl_act_e;

    // Operand selection pair, widened to a common container
    typedef struct packed {
        logic        from_reg;
        logic [31:0] imm_val;
        logic [31:0] reg_val;
    } hwl_opnd_t;

    // Sign-extend an offw-bit offset and add it to a base address
    function automatic logic [31:0] rel_target(input logic [31:0] base,
                                               input logic [31:0] off,
                                               input int unsigned offw);
        logic signed [31:0] ext;
        ext = $signed(off << (32 - offw)) >>> (32 - offw);
        return base + ext;
    endfunction

    function automatic logic [31:0] pick_opnd(input hwl_opnd_t o);
        return o.from_reg ? o.reg_val : o.imm_val;
    endfunction

endpackage

// File: rtl/hwl_opnd_mux.sv
module hwl_opnd_mux #(
    parameter int W = 9
) (
    input  logic         from_reg,
    input  logic [W-1:0] imm_val,
    input  logic [W-1:0] reg_val,
    output logic [W-1:0] sel_val
);
    import hwl_pkg::*;

    hwl_opnd_t pair;

    always_comb begin
        pair.from_reg = from_reg;
        pair.imm_val  = 32'(imm_val);
        pair.reg_val  = 32'(reg_val);
        sel_val       = W'(pick_opnd(pair));
    end

endmodule

// File: rtl/hwl_pc_steer.sv
module hwl_pc_steer #(
    parameter int AW = 16,
    parameter int LW = 9,
    parameter int BW = 9
) (
    input  logic          retire,
    input  logic          br_taken,
    input  logic          br_relative,
    input  logic [BW-1:0] br_offset,
    input  logic [AW-1:0] br_target,
    input  logic          rep_issue,
    input  logic [LW-1:0] rep_len,
    input  logic [AW-1:0] pc_cur,
    input  logic          loop_active,
    input  logic [AW-1:0] loop_start,
    input  logic [AW-1:0] loop_last,
    input  logic          loop_more,
    output logic [AW-1:0] pc_next,
    output hwl_pkg::hwl_act_e act
);
    import hwl_pkg::*;

    logic [AW-1:0] rel_pc;
    logic          at_last;

    // Relative target always from the branch's own address
    assign rel_pc  = AW'(rel_target(32'(pc_cur), 32'(br_offset), BW));
    assign at_last = loop_active && (pc_cur == loop_last);

    always_comb begin
        act     = ACT_SEQ;
        pc_next = pc_cur + 1'b1;
        if (!retire) begin
            act     = ACT_HOLD;
            pc_next = pc_cur;
        end else if (br_taken) begin
            act     = ACT_BRANCH;
            pc_next = br_relative ? rel_pc : br_target;
        end else if (rep_issue) begin
            act = (rep_len == '0) ? ACT_REP_NULL : ACT_REP;
        end else if (at_last) begin
            if (loop_more) begin
                act     = ACT_LOOPBACK;
                pc_next = loop_start;
            end else begin
                act = ACT_EXIT;
            end
        end
    end

endmodule

// File: rtl/hwl_loop_state.sv
module hwl_loop_state #(
    parameter int AW = 16,
    parameter int LW = 9,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  hwl_pkg::hwl_act_e act,
    input  logic [AW-1:0] pc_cur,
    input  logic [LW-1:0] rep_len,
    input  logic [CW-1:0] rep_cnt,
    output logic          loop_active,
    output logic [AW-1:0] loop_start,
    output logic [AW-1:0] loop_last,
    output logic          loop_more
);
    import hwl_pkg::*;

    logic          unlimited;
    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            loop_active <= 1'b0;
            unlimited   <= 1'b0;
            loop_start  <= '0;
            loop_last   <= '0;
            left        <= '0;
        end else begin
            case (act)
                ACT_BRANCH, ACT_REP_NULL, ACT_EXIT: begin
                    loop_active <= 1'b0;
                end
                ACT_REP: begin
                    loop_active <= 1'b1;
                    unlimited   <= (rep_cnt == '0);
                    left        <= rep_cnt;
                    loop_start  <= pc_cur + 1'b1;
                    loop_last   <= pc_cur + AW'(rep_len);
                end
                ACT_LOOPBACK: begin
                    if (!unlimited) left <= left - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign loop_more = unlimited || (left > CW'(1));

    // R2: a cycle with no retire leaves the loop state untouched
    a_r2_stall_keeps_state: assert property (@(posedge clk) disable iff (rst)
        act == ACT_HOLD |=> $stable(loop_active) && $stable(left) && $stable(loop_start));

    // R3: a taken branch cancels the loop
    a_r3_branch_ends_loop: assert property (@(posedge clk) disable iff (rst)
        act == ACT_BRANCH |=> !loop_active);

    // R5: body bounds follow the issue address and length
    a_r5_block_bounds: assert property (@(posedge clk) disable iff (rst)
        act == ACT_REP |=> loop_active
            && loop_start == AW'($past(pc_cur) + 1'b1)
            && loop_last  == AW'($past(pc_cur) + AW'($past(rep_len))));

    // R6: a zero-length issue leaves no loop running
    a_r6_null_rep_idle: assert property (@(posedge clk) disable iff (rst)
        act == ACT_REP_NULL |=> !loop_active);

    // R10: a counted loop never runs with zero iterations left
    a_r10_count_nonzero: assert property (@(posedge clk) disable iff (rst)
        loop_active && !unlimited |-> left != '0);

endmodule

// File: rtl/hwl_rep_seq.sv
module hwl_rep_seq #(
    parameter int AW = 16,
    parameter int LW = 9,
    parameter int CW = 16,
    parameter int BW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rep_issue,
    input  logic [LW-1:0] rep_len_imm,
    input  logic [LW-1:0] rep_len_reg,
    input  logic          rep_len_from_reg,
    input  logic [CW-1:0] rep_cnt_imm,
    input  logic [CW-1:0] rep_cnt_reg,
    input  logic          rep_cnt_from_reg,
    input  logic [AW-1:0] pc_cur,
    input  logic          retire,
    input  logic          br_taken,
    input  logic          br_relative,
    input  logic [BW-1:0] br_offset,
    input  logic [AW-1:0] br_target,
    input  logic          irq_req,
    output logic [AW-1:0] pc_next,
    output logic          loop_active,
    output logic          irq_hold
);
    import hwl_pkg::*;

    logic [LW-1:0] len_sel;
    logic [CW-1:0] cnt_sel;
    logic [AW-1:0] loop_start;
    logic [AW-1:0] loop_last;
    logic          loop_more;
    hwl_act_e      act;

    hwl_opnd_mux #(.W(LW)) u_len_mux (
        .from_reg (rep_len_from_reg),
        .imm_val  (rep_len_imm),
        .reg_val  (rep_len_reg),
        .sel_val  (len_sel)
    );

    hwl_opnd_mux #(.W(CW)) u_cnt_mux (
        .from_reg (rep_cnt_from_reg),
        .imm_val  (rep_cnt_imm),
        .reg_val  (rep_cnt_reg),
        .sel_val  (cnt_sel)
    );

    hwl_pc_steer #(.AW(AW), .LW(LW), .BW(BW)) u_steer (
        .retire      (retire),
        .br_taken    (br_taken),
        .br_relative (br_relative),
        .br_offset   (br_offset),
        .br_target   (br_target),
        .rep_issue   (rep_issue),
        .rep_len     (len_sel),
        .pc_cur      (pc_cur),
        .loop_active (loop_active),
        .loop_start  (loop_start),
        .loop_last   (loop_last),
        .loop_more   (loop_more),
        .pc_next     (pc_next),
        .act         (act)
    );

    hwl_loop_state #(.AW(AW), .LW(LW), .CW(CW)) u_state (
        .clk         (clk),
        .rst         (rst),
        .act         (act),
        .pc_cur      (pc_cur),
        .rep_len     (len_sel),
        .rep_cnt     (cnt_sel),
        .loop_active (loop_active),
        .loop_start  (loop_start),
        .loop_last   (loop_last),
        .loop_more   (loop_more)
    );

    assign irq_hold = irq_req & loop_active;

    // R9: a request during an active loop is held
    a_r9_irq_held: assert property (@(posedge clk) disable iff (rst)
        loop_active && irq_req |-> irq_hold);

    // R9: nothing is held once the loop is idle
    a_r9_irq_free: assert property (@(posedge clk) disable iff (rst)
        !loop_active |-> !irq_hold);

    // R2: a stalled cycle keeps the PC where it is
    a_r2_stall_pc: assert property (@(posedge clk) disable iff (rst)
        !retire |-> pc_next == pc_cur);

endmodule

// File: tb/hwl_rep_seq_tb.sv
module hwl_rep_seq_tb;
    localparam int AW = 16;
    localparam int LW = 9;
    localparam int CW = 16;
    localparam int BW = 9;
    localparam int MASK = (1 << AW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic          rep_issue, rep_len_from_reg, rep_cnt_from_reg;
    logic [LW-1:0] rep_len_imm, rep_len_reg;
    logic [CW-1:0] rep_cnt_imm, rep_cnt_reg;
    logic [AW-1:0] pc_cur, br_target;
    logic          retire, br_taken, br_relative, irq_req;
    logic [BW-1:0] br_offset;
    logic [AW-1:0] pc_next;
    logic          loop_active, irq_hold;

    hwl_rep_seq #(.AW(AW), .LW(LW), .CW(CW), .BW(BW)) u_dut (
        .clk(clk), .rst(rst),
        .rep_issue(rep_issue),
        .rep_len_imm(rep_len_imm), .rep_len_reg(rep_len_reg), .rep_len_from_reg(rep_len_from_reg),
        .rep_cnt_imm(rep_cnt_imm), .rep_cnt_reg(rep_cnt_reg), .rep_cnt_from_reg(rep_cnt_from_reg),
        .pc_cur(pc_cur), .retire(retire),
        .br_taken(br_taken), .br_relative(br_relative), .br_offset(br_offset), .br_target(br_target),
        .irq_req(irq_req),
        .pc_next(pc_next), .loop_active(loop_active), .irq_hold(irq_hold)
    );

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    bit done = 0;

    // Behavioural reference state
    int pc;
    int m_imm;
    bit m_act, m_inf;
    int m_start, m_last, m_rem;

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic clear_in();
        rep_issue = 0; rep_len_imm = '0; rep_len_reg = '0; rep_len_from_reg = 0;
        rep_cnt_imm = '0; rep_cnt_reg = '0; rep_cnt_from_reg = 0;
        retire = 0; br_taken = 0; br_relative = 0; br_offset = '0; br_target = '0;
        m_imm = 0;
    endtask

    // One clock: compare outputs with the model, then advance the model
    task automatic cycle(input string tag);
        int e;
        int len, cnt;
        pc_cur = AW'(pc);
        #1;
        len = rep_len_from_reg ? int'(rep_len_reg) : int'(rep_len_imm);
        cnt = rep_cnt_from_reg ? int'(rep_cnt_reg) : int'(rep_cnt_imm);
        e = (pc + 1) & MASK;
        chk(tag, "loop_active", int'(loop_active), int'(m_act));
        chk(tag, "irq_hold", int'(irq_hold), int'(m_act && irq_req));
        if (!retire) begin
            e = pc;
        end else if (br_taken) begin
            e = br_relative ? ((pc + m_imm) & MASK) : int'(br_target);
            m_act = 0;
        end else if (rep_issue) begin
            if (len == 0) m_act = 0;
            else begin
                m_act = 1; m_start = (pc + 1) & MASK; m_last = (pc + len) & MASK;
                m_inf = (cnt == 0); m_rem = cnt;
            end
        end else if (m_act && pc == m_last) begin
            if (m_inf || m_rem > 1) begin
                e = m_start;
                if (!m_inf) m_rem--;
            end else m_act = 0;
        end
        chk(tag, "pc_next", int'(pc_next), e);
        pc = e;
        @(negedge clk);
        clear_in();
    endtask

    task automatic plain(input string tag);
        retire = 1; cycle(tag);
    endtask

    task automatic stall(input string tag);
        retire = 0; cycle(tag);
    endtask

    task automatic rep(input string tag, input int len, input int cnt);
        retire = 1; rep_issue = 1; rep_len_imm = LW'(len); rep_cnt_imm = CW'(cnt);
        cycle(tag);
    endtask

    task automatic rep_reg(input string tag, input int len, input int cnt);
        retire = 1; rep_issue = 1;
        rep_len_imm = LW'(7); rep_cnt_imm = CW'(9);
        rep_len_reg = LW'(len); rep_cnt_reg = CW'(cnt);
        rep_len_from_reg = 1; rep_cnt_from_reg = 1;
        cycle(tag);
    endtask

    task automatic brel(input string tag, input int imm);
        retire = 1; br_taken = 1; br_relative = 1; br_offset = BW'(imm);
        br_target = AW'(16'h5A5A); m_imm = imm;
        cycle(tag);
    endtask

    task automatic babs(input string tag, input int t);
        retire = 1; br_taken = 1; br_relative = 0; br_target = AW'(t); br_offset = BW'(3);
        cycle(tag);
    endtask

    // Run plain instructions until the loop ends; return body retires
    task automatic drain(input string tag, input bit with_stalls, output int k);
        k = 0;
        while (loop_active && k < 2000) begin
            if (with_stalls) begin stall(tag); stall(tag); end
            plain(tag);
            k++;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int k;
        clear_in();
        irq_req = 1; pc = 0; pc_cur = '0;
        m_act = 0; m_inf = 0; m_start = 0; m_last = 0; m_rem = 0;
        repeat (3) @(negedge clk);
        chk("R1", "reset loop_active", int'(loop_active), 0);
        chk("R9", "reset irq_hold", int'(irq_hold), 0);
        rst = 0; irq_req = 0;

        // R1: sequential flow
        pc = 20;
        repeat (3) plain("R1");
        stall("R2");

        // R5: counted loop, L=3 N=2
        pc = 40;
        rep("R5", 3, 2);
        drain("R5", 0, k);
        chk("R5", "body retires", k, 6);
        plain("R5");

        // R10: count of one gives a single pass
        pc = 60;
        rep("R10", 5, 1);
        drain("R10", 0, k);
        chk("R10", "single pass retires", k, 5);

        // R2: stalls inside the body do not count
        pc = 80;
        rep("R2", 2, 3);
        drain("R2", 1, k);
        chk("R2", "retires with stalls", k, 6);

        // R10 / R9: unlimited loop with an interrupt pending, then cancel
        pc = 100;
        rep("R10", 3, 0);
        irq_req = 1;
        repeat (9) plain("R9");
        chk("R10", "unlimited still active", int'(loop_active), 1);
        chk("R9", "irq held", int'(irq_hold), 1);
        plain("R9");
        brel("R3", 5);
        chk("R3", "cancelled loop_active", int'(loop_active), 0);
        chk("R9", "irq released", int'(irq_hold), 0);
        irq_req = 0;

        // R4: relative branches at first, middle and final positions
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 3; p++) begin
                pc = 200 + 40 * (s * 3 + p);
                rep("R4", 3, 4);
                repeat (3 + p) plain("R4");
                brel("R4", (s == 1) ? -7 : 5);
                chk("R3", "branch ends loop", int'(loop_active), 0);
                plain("R4");
                plain("R4");
            end
        end

        // R4: backward relative wrap below zero, and an absolute target
        pc = 3;
        brel("R4", -7);
        chk("R4", "wrapped target pc", pc, 16'hFFFC);
        pc = 500;
        rep("R4", 2, 2);
        plain("R4");
        babs("R4", 16'h1234);
        plain("R4");

        // R7: a repeat inside a repeat replaces the outer one
        pc = 600;
        rep("R7", 4, 3);
        plain("R7");
        plain("R7");
        rep("R7", 2, 2);
        drain("R7", 0, k);
        chk("R7", "inner-only retires", k, 4);

        // R6: zero length is a no-op and ends a running loop
        pc = 700;
        rep("R6", 0, 5);
        chk("R6", "zero length idle", int'(loop_active), 0);
        rep("R6", 3, 0);
        plain("R6");
        rep("R6", 0, 2);
        chk("R6", "zero length ends loop", int'(loop_active), 0);
        plain("R6");

        // R8: operands from the register form
        pc = 800;
        rep_reg("R8", 2, 3);
        drain("R8", 0, k);
        chk("R8", "register operand retires", k, 6);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule